// File: doc/BRIEF.md
# Parameter Register Loader

This block fills a set of parameter registers from a single 16-bit word stream. A transaction opens with an address word. The upper byte of that word selects a register class and the lower byte selects an entry within the class. A fixed number of data words then follows, and that number is set by the class. Bias entries take one word, flag counters take two, packed round/select/limit entries take four, and coefficient sets take ten. The loader takes one word on every clock edge at which the pause input is low. The stream can therefore run back to back, and the source can stretch it at will by raising pause.

Data words for a multi-word entry are held in a staging buffer. The target entry is written in a single cycle, on the edge that takes the final word, so the datapath downstream never sees a half-written entry. An address that matches no class, or that matches a class but names an entry index that does not exist, is dropped. The word after it is then treated as an address. All parameter registers appear as flat output vectors for the arithmetic datapath, which lies outside this block.

Top module: `plw_loader`

## Requirements
- R1: After reset, every parameter output reads zero and the loader treats the first word taken as an address.
- R2: Address 09hh (hh below NUM_BIAS) is followed by one data word that becomes output bias entry hh. Address 0Bhh does the same for input bias entry hh. Entry i occupies bits [16i+15:16i] of its output vector.
- R3: Address 00hh (hh below NUM_SETS) is followed by COEF_WORDS data words. The k-th word sent becomes coefficient k of set hh, at bits [16(hh*COEF_WORDS+k)+15 : 16(hh*COEF_WORDS+k)] of coef_o.
- R4: Address 0C00 or 0C01 is followed by two data words forming a 20-bit counter value. The first word gives bits 15:0 and bits 3:0 of the second word give bits 19:16. The remaining bits of the second word are ignored. Counter f sits at bits [20f+19:20f].
- R5: Address 0Ehh (hh below NUM_RSL) is followed by four data words. Word 0 gives round[15:0]. Word 1 bits 3:0 give round[19:16], and word 1 bits 5:4 give the 2-bit select. Word 2 bits 12:0 give the upper limit and word 3 bits 12:0 give the lower limit. The 48-bit entry packs {round, select, upper, lower} from MSB to LSB, and entry r sits at bits [48r+47:48r].
- R6: A multi-word entry keeps its old value until the edge that takes its final data word. It then changes to the complete new value in that single cycle.
- R7: The word taken on the edge after a transaction's final data word is decoded as a new address, with no idle cycle required.
- R8: While pause is high, the loader takes no word, holds its position within the transaction and writes nothing. Once pause returns low, it continues with the next word of the same transaction.
- R9: An address word with an unknown upper byte, or with an entry index beyond the class size, changes no register. The next word taken is decoded as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pause_i | input | 1 | When high, the load port is ignored and the loader holds its state |
| ld_word_i | input | 16 | Load port: address or data word |
| obias_o | output | 16*NUM_BIAS | Output bias entries |
| ibias_o | output | 16*NUM_BIAS | Input bias entries |
| coef_o | output | 16*COEF_WORDS*NUM_SETS | Coefficient sets |
| flag_cnt_o | output | 40 | Two 20-bit flag counter values |
| rsl_o | output | 48*NUM_RSL | Packed round/select/limit entries |

## Verification
The assertions assume that the load port is never undefined while pause is low. Every such cycle consumes a word, so the bench always drives either a real word or the idle code FFFF, which falls into no class. The stability checks also assume that the stream's framing stays intact once an address is taken, because a dropped word would shift every later address into a data slot. The bench therefore sends whole transactions only. It places junk words only in paused cycles or in the single address slot that follows a rejected address.

// File: rtl/plw_pkg.sv
package plw_pkg;
  localparam int WORD_W  = 16;
  localparam int RND_W   = 20;
  localparam int SEL_W   = 2;
  localparam int LIM_W   = 13;
  localparam int RSL_W   = RND_W + SEL_W + 2 * LIM_W;
  localparam int FLAG_W  = 20;
  localparam int NUM_FLAG = 2;

  localparam logic [7:0] RGN_COEF  = 8'h00;
  localparam logic [7:0] RGN_OBIAS = 8'h09;
  localparam logic [7:0] RGN_IBIAS = 8'h0B;
  localparam logic [7:0] RGN_FLAG  = 8'h0C;
  localparam logic [7:0] RGN_RSL   = 8'h0E;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_OBIAS = 3'd1,
    CLS_IBIAS = 3'd2,
    CLS_COEF  = 3'd3,
    CLS_FLAG  = 3'd4,
    CLS_RSL   = 3'd5
  } plw_cls_e;
endpackage

// File: rtl/plw_decode.sv
module plw_decode
  import plw_pkg::*;
#(
  parameter int NUM_BIAS   = 8,
  parameter int NUM_SETS   = 4,
  parameter int NUM_RSL    = 4,
  parameter int COEF_WORDS = 10,
  parameter int CNT_W      = 4
) (
  input  logic [WORD_W-1:0] addr_i,
  output plw_cls_e          cls_o,
  output logic [7:0]        idx_o,
  output logic [CNT_W-1:0]  need_o
);
  logic [7:0] rgn;
  assign rgn   = addr_i[15:8];
  assign idx_o = addr_i[7:0];

  always_comb begin
    cls_o  = CLS_NONE;
    need_o = '0;
    unique case (rgn)
      RGN_COEF: if (int'(idx_o) < NUM_SETS) begin
        cls_o  = CLS_COEF;
        need_o = CNT_W'(COEF_WORDS);
      end
      RGN_OBIAS: if (int'(idx_o) < NUM_BIAS) begin
        cls_o  = CLS_OBIAS;
        need_o = CNT_W'(1);
      end
      RGN_IBIAS: if (int'(idx_o) < NUM_BIAS) begin
        cls_o  = CLS_IBIAS;
        need_o = CNT_W'(1);
      end
      RGN_FLAG: if (int'(idx_o) < NUM_FLAG) begin
        cls_o  = CLS_FLAG;
        need_o = CNT_W'(2);
      end
      RGN_RSL: if (int'(idx_o) < NUM_RSL) begin
        cls_o  = CLS_RSL;
        need_o = CNT_W'(4);
      end
      default: begin
        cls_o  = CLS_NONE;
        need_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/plw_seq.sv
module plw_seq
  import plw_pkg::*;
#(
  parameter int COEF_WORDS = 10,
  parameter int CNT_W      = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pause_i,
  input  logic [WORD_W-1:0]            word_i,
  input  plw_cls_e                     dec_cls_i,
  input  logic [7:0]                   dec_idx_i,
  input  logic [CNT_W-1:0]             dec_need_i,
  output logic                         in_data_o,
  output logic [CNT_W-1:0]             cnt_o,
  output logic                         commit_o,
  output plw_cls_e                     commit_cls_o,
  output logic [7:0]                   commit_idx_o,
  output logic [COEF_WORDS*WORD_W-1:0] commit_words_o
);
  logic              in_data_q, in_data_d;
  plw_cls_e          cls_q, cls_d;
  logic [7:0]        idx_q, idx_d;
  logic [CNT_W-1:0]  need_q, need_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              stage_we;
  logic              commit;
  logic [WORD_W-1:0] stage_q [COEF_WORDS];

  always_comb begin
    in_data_d = in_data_q;
    cls_d     = cls_q;
    idx_d     = idx_q;
    need_d    = need_q;
    cnt_d     = cnt_q;
    stage_we  = 1'b0;
    commit    = 1'b0;
    if (!pause_i) begin
      if (!in_data_q) begin
        if (dec_cls_i != CLS_NONE) begin
          in_data_d = 1'b1;
          cls_d     = dec_cls_i;
          idx_d     = dec_idx_i;
          need_d    = dec_need_i;
          cnt_d     = '0;
        end
      end else if (cnt_q == need_q - CNT_W'(1)) begin
        commit    = 1'b1;
        in_data_d = 1'b0;
      end else begin
        stage_we = 1'b1;
        cnt_d    = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;
      cls_q     <= CLS_NONE;
      idx_q     <= '0;
      need_q    <= '0;
      cnt_q     <= '0;
    end else begin
      in_data_q <= in_data_d;
      cls_q     <= cls_d;
      idx_q     <= idx_d;
      need_q    <= need_d;
      cnt_q     <= cnt_d;
    end
  end

  for (genvar k = 0; k < COEF_WORDS; k++) begin : g_stage
    logic we_k;
    assign we_k = stage_we && (cnt_q == CNT_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[k] <= '0;
      end else if (we_k) begin
        stage_q[k] <= word_i;
      end
    end
    assign commit_words_o[k*WORD_W +: WORD_W] =
      (cnt_q == CNT_W'(k)) ? word_i : stage_q[k];
  end

  assign in_data_o    = in_data_q;
  assign cnt_o        = cnt_q;
  assign commit_o     = commit;
  assign commit_cls_o = cls_q;
  assign commit_idx_o = idx_q;
endmodule

// File: rtl/plw_bank.sv
module plw_bank
  import plw_pkg::*;
#(
  parameter int NUM_BIAS   = 8,
  parameter int NUM_SETS   = 4,
  parameter int NUM_RSL    = 4,
  parameter int COEF_WORDS = 10
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  commit_i,
  input  plw_cls_e                              cls_i,
  input  logic [7:0]                            idx_i,
  input  logic [COEF_WORDS*WORD_W-1:0]          words_i,
  output logic [NUM_BIAS*WORD_W-1:0]            obias_o,
  output logic [NUM_BIAS*WORD_W-1:0]            ibias_o,
  output logic [NUM_SETS*COEF_WORDS*WORD_W-1:0] coef_o,
  output logic [NUM_FLAG*FLAG_W-1:0]            flag_cnt_o,
  output logic [NUM_RSL*RSL_W-1:0]              rsl_o
);
  localparam int SET_W = COEF_WORDS * WORD_W;

  logic [FLAG_W-1:0] flag_val;
  logic [RSL_W-1:0]  rsl_val;

  assign flag_val = {words_i[WORD_W +: 4], words_i[0 +: WORD_W]};
  assign rsl_val  = {words_i[WORD_W +: 4], words_i[0 +: WORD_W],
                     words_i[WORD_W+4 +: SEL_W],
                     words_i[2*WORD_W +: LIM_W],
                     words_i[3*WORD_W +: LIM_W]};

  for (genvar i = 0; i < NUM_BIAS; i++) begin : g_bias
    logic we_o, we_i;
    assign we_o = commit_i && (cls_i == CLS_OBIAS) && (idx_i == 8'(i));
    assign we_i = commit_i && (cls_i == CLS_IBIAS) && (idx_i == 8'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        obias_o[i*WORD_W +: WORD_W] <= '0;
      end else if (we_o) begin
        obias_o[i*WORD_W +: WORD_W] <= words_i[0 +: WORD_W];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ibias_o[i*WORD_W +: WORD_W] <= '0;
      end else if (we_i) begin
        ibias_o[i*WORD_W +: WORD_W] <= words_i[0 +: WORD_W];
      end
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_coef
    logic we;
    assign we = commit_i && (cls_i == CLS_COEF) && (idx_i == 8'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coef_o[s*SET_W +: SET_W] <= '0;
      end else if (we) begin
        coef_o[s*SET_W +: SET_W] <= words_i;
      end
    end
  end

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    logic we;
    assign we = commit_i && (cls_i == CLS_FLAG) && (idx_i == 8'(f));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_cnt_o[f*FLAG_W +: FLAG_W] <= '0;
      end else if (we) begin
        flag_cnt_o[f*FLAG_W +: FLAG_W] <= flag_val;
      end
    end
  end

  for (genvar r = 0; r < NUM_RSL; r++) begin : g_rsl
    logic we;
    assign we = commit_i && (cls_i == CLS_RSL) && (idx_i == 8'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsl_o[r*RSL_W +: RSL_W] <= '0;
      end else if (we) begin
        rsl_o[r*RSL_W +: RSL_W] <= rsl_val;
      end
    end
  end
endmodule

// File: rtl/plw_loader.sv
module plw_loader
  import plw_pkg::*;
#(
  parameter int NUM_BIAS   = 8,
  parameter int NUM_SETS   = 4,
  parameter int NUM_RSL    = 4,
  parameter int COEF_WORDS = 10
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  pause_i,
  input  logic [WORD_W-1:0]                     ld_word_i,
  output logic [NUM_BIAS*WORD_W-1:0]            obias_o,
  output logic [NUM_BIAS*WORD_W-1:0]            ibias_o,
  output logic [NUM_SETS*COEF_WORDS*WORD_W-1:0] coef_o,
  output logic [NUM_FLAG*FLAG_W-1:0]            flag_cnt_o,
  output logic [NUM_RSL*RSL_W-1:0]              rsl_o
);
  localparam int CNT_W = $clog2(COEF_WORDS + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  plw_cls_e                     dec_cls;
  logic [7:0]                   dec_idx;
  logic [CNT_W-1:0]             dec_need;
  logic                         seq_in_data;
  logic [CNT_W-1:0]             seq_cnt;
  logic                         commit_vld;
  plw_cls_e                     commit_cls;
  logic [7:0]                   commit_idx;
  logic [COEF_WORDS*WORD_W-1:0] commit_words;

  plw_decode #(
    .NUM_BIAS(NUM_BIAS), .NUM_SETS(NUM_SETS), .NUM_RSL(NUM_RSL),
    .COEF_WORDS(COEF_WORDS), .CNT_W(CNT_W)
  ) decode_i (
    .addr_i (ld_word_i),
    .cls_o  (dec_cls),
    .idx_o  (dec_idx),
    .need_o (dec_need)
  );

  plw_seq #(
    .COEF_WORDS(COEF_WORDS), .CNT_W(CNT_W)
  ) seq_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_int),
    .pause_i        (pause_i),
    .word_i         (ld_word_i),
    .dec_cls_i      (dec_cls),
    .dec_idx_i      (dec_idx),
    .dec_need_i     (dec_need),
    .in_data_o      (seq_in_data),
    .cnt_o          (seq_cnt),
    .commit_o       (commit_vld),
    .commit_cls_o   (commit_cls),
    .commit_idx_o   (commit_idx),
    .commit_words_o (commit_words)
  );

  plw_bank #(
    .NUM_BIAS(NUM_BIAS), .NUM_SETS(NUM_SETS), .NUM_RSL(NUM_RSL),
    .COEF_WORDS(COEF_WORDS)
  ) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .commit_i   (commit_vld),
    .cls_i      (commit_cls),
    .idx_i      (commit_idx),
    .words_i    (commit_words),
    .obias_o    (obias_o),
    .ibias_o    (ibias_o),
    .coef_o     (coef_o),
    .flag_cnt_o (flag_cnt_o),
    .rsl_o      (rsl_o)
  );
endmodule

// File: rtl/plw_loader_chk.sv
module plw_loader_chk
  import plw_pkg::*;
#(
  parameter int NUM_SETS   = 4,
  parameter int NUM_RSL    = 4,
  parameter int COEF_WORDS = 10,
  parameter int CNT_W      = 4
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  pause_i,
  input plw_cls_e                              dec_cls,
  input logic                                  in_data,
  input logic [CNT_W-1:0]                      cnt,
  input logic                                  commit,
  input plw_cls_e                              commit_cls,
  input logic [NUM_SETS*COEF_WORDS*WORD_W-1:0] coef_o,
  input logic [NUM_RSL*RSL_W-1:0]              rsl_o
);
  assert_coef_atomic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && commit_cls == CLS_COEF) |=> $stable(coef_o));

  assert_rsl_atomic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && commit_cls == CLS_RSL) |=> $stable(rsl_o));

  assert_addr_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !in_data);

  assert_pause_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> ($stable(in_data) && $stable(cnt)));

  assert_pause_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |-> !commit);

  assert_unknown_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_data && !pause_i && dec_cls == CLS_NONE) |=> !in_data);
endmodule

bind plw_loader plw_loader_chk #(
  .NUM_SETS(NUM_SETS), .NUM_RSL(NUM_RSL),
  .COEF_WORDS(COEF_WORDS), .CNT_W(CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_int),
  .pause_i    (pause_i),
  .dec_cls    (dec_cls),
  .in_data    (seq_in_data),
  .cnt        (seq_cnt),
  .commit     (commit_vld),
  .commit_cls (commit_cls),
  .coef_o     (coef_o),
  .rsl_o      (rsl_o)
);

// File: tb/plw_loader_tb_top.sv
`timescale 1ns/1ps
module plw_loader_tb_top;
  localparam int NB = 8;
  localparam int NS = 4;
  localparam int NR = 4;
  localparam int CW = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        pause_i;
  logic [15:0] ld_word_i;
  logic [NB*16-1:0]    obias_o, ibias_o;
  logic [NS*CW*16-1:0] coef_o;
  logic [39:0]         flag_cnt_o;
  logic [NR*48-1:0]    rsl_o;

  always #2.5 clk_i = ~clk_i;

  plw_loader #(.NUM_BIAS(NB), .NUM_SETS(NS), .NUM_RSL(NR), .COEF_WORDS(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i), .ld_word_i(ld_word_i),
    .obias_o(obias_o), .ibias_o(ibias_o), .coef_o(coef_o),
    .flag_cnt_o(flag_cnt_o), .rsl_o(rsl_o)
  );

  logic [15:0] m_obias [NB];
  logic [15:0] m_ibias [NB];
  logic [15:0] m_coef  [NS*CW];
  logic [19:0] m_flag  [2];
  logic [47:0] m_rsl   [NR];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic cmp(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [1023:0] e_ob, e_ib, e_cf, e_fl, e_rs;
    e_ob = '0; e_ib = '0; e_cf = '0; e_fl = '0; e_rs = '0;
    for (int i = 0; i < NB; i++) begin
      e_ob[i*16 +: 16] = m_obias[i];
      e_ib[i*16 +: 16] = m_ibias[i];
    end
    for (int i = 0; i < NS*CW; i++) e_cf[i*16 +: 16] = m_coef[i];
    for (int i = 0; i < 2; i++) e_fl[i*20 +: 20] = m_flag[i];
    for (int i = 0; i < NR; i++) e_rs[i*48 +: 48] = m_rsl[i];
    cmp({tag, " obias"}, 1024'(obias_o), e_ob);
    cmp({tag, " ibias"}, 1024'(ibias_o), e_ib);
    cmp({tag, " coef"},  1024'(coef_o),  e_cf);
    cmp({tag, " flag"},  1024'(flag_cnt_o), e_fl);
    cmp({tag, " rsl"},   1024'(rsl_o),   e_rs);
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk_i);
    pause_i   = 1'b0;
    ld_word_i = w;
  endtask

  task automatic pause_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      pause_i   = 1'b1;
      ld_word_i = 16'h0900 ^ 16'(i);
    end
  endtask

  task automatic idle_check(input string tag);
    send_word(16'hFFFF);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] rnd;
    logic [1:0]  sel;
    logic [12:0] up, lo;
    logic [19:0] fv;
    for (int i = 0; i < NB; i++) begin m_obias[i] = '0; m_ibias[i] = '0; end
    for (int i = 0; i < NS*CW; i++) m_coef[i] = '0;
    m_flag[0] = '0; m_flag[1] = '0;
    for (int i = 0; i < NR; i++) m_rsl[i] = '0;

    rst_ni = 1'b0; pause_i = 1'b0; ld_word_i = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_all("R1");

    // R2: every bias entry of both regions
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < NB; i++) begin
        logic [15:0] v;
        v = 16'h007F + 16'(i * 16'h0111) + 16'(g * 16'h4000);
        send_word({(g == 0) ? 8'h09 : 8'h0B, 8'(i)});
        send_word(v);
        if (g == 0) m_obias[i] = v; else m_ibias[i] = v;
        idle_check("R2");
      end
    end

    // R9: out-of-range index, then unknown region; following word must be an address
    send_word({8'h09, 8'(NB)});
    send_word(16'h0B00);
    send_word(16'h1234);
    m_ibias[0] = 16'h1234;
    idle_check("R9 range");
    send_word(16'h0700);
    send_word(16'h0901);
    send_word(16'hBEEF);
    m_obias[1] = 16'hBEEF;
    idle_check("R9 region");

    // R3 + R6: coefficient sets, with mid-transfer checks
    for (int s = 0; s < NS; s++) begin
      send_word(16'(s));
      for (int k = 0; k < CW; k++) begin
        send_word(16'(s * 256 + k));
        if (k == CW - 1) check_all("R6 before last word");
        if (s == 1 && k == 4) begin
          pause_cycles(5);
          check_all("R8 paused mid set");
        end
      end
      for (int k = 0; k < CW; k++) m_coef[s*CW + k] = 16'(s * 256 + k);
      idle_check("R3");
    end

    // R4: flag counters, junk in upper bits of second word
    for (int f = 0; f < 2; f++) begin
      fv = 20'hB3C27 + 20'(f * 20'h11111);
      send_word(16'h0C00 + 16'(f));
      send_word(fv[15:0]);
      pause_cycles(2);
      check_all("R8 paused mid flag");
      send_word({12'hA50, fv[19:16]});
      m_flag[f] = fv;
      idle_check("R4");
    end

    // R5 + R6: round/select/limit entries
    for (int r = 0; r < NR; r++) begin
      rnd = 20'h00020 + 20'(r * 20'h3A1F1);
      sel = 2'(r);
      up  = 13'h0FFF - 13'(r * 3);
      lo  = 13'h1001 + 13'(r * 5);
      send_word(16'h0E00 + 16'(r));
      send_word(rnd[15:0]);
      send_word({10'h3C1, sel, rnd[19:16]});
      send_word({3'b111, up});
      send_word({3'b101, lo});
      check_all("R6 rsl before last word");
      m_rsl[r] = {rnd, sel, up, lo};
      idle_check("R5");
    end

    // R7: back-to-back transactions with no idle word
    send_word(16'h0903); send_word(16'h0010);
    send_word(16'h0B05); send_word(16'h0055);
    send_word(16'h0C01); send_word(16'hAAAA); send_word(16'h0007);
    send_word(16'h0902); send_word(16'h0222);
    m_obias[3] = 16'h0010; m_ibias[5] = 16'h0055;
    m_flag[1] = 20'h7AAAA; m_obias[2] = 16'h0222;
    idle_check("R7");

    // R8: pause in the address slot with valid-looking junk on the port
    pause_cycles(4);
    check_all("R8 paused idle");
    send_word(16'h0B07);
    pause_cycles(3);
    send_word(16'h7777);
    m_ibias[7] = 16'h7777;
    idle_check("R8 resume");

    // R1: reset again clears everything, loader restarts on an address
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NB; i++) begin m_obias[i] = '0; m_ibias[i] = '0; end
    for (int i = 0; i < NS*CW; i++) m_coef[i] = '0;
    m_flag[0] = '0; m_flag[1] = '0;
    for (int i = 0; i < NR; i++) m_rsl[i] = '0;
    repeat (3) @(negedge clk_i);
    check_all("R1 re-reset");
    send_word(16'h0904); send_word(16'h4444);
    m_obias[4] = 16'h4444;
    idle_check("R1 first word is address");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule